// File: doc/BRIEF.md
# Strobe/Handshake Read Bus Interface

This block pairs a bus master with a memory-like slave. They carry out single-byte reads over a request line, a wait line and an 8-bit data bus. A user pulses `start` with an address. The master raises its request and counts out a fixed access window of `TA` clock cycles. It takes the byte off the bus once the window has passed and the wait line is low, then drops the request. It shows the byte on `rd_data` together with a one-cycle `done` pulse.

The slave needs `LAT` clock cycles to produce a byte. When `LAT` is no larger than `TA`, it answers inside the window and never touches the wait line, so the transfer is a plain strobe. When `LAT` exceeds `TA`, it raises wait in the cycle after it sees the request. It lowers wait when its byte is ready, so the same master then runs a handshake. The slave's storage is a small register array. It is loaded at reset with the computed pattern `(index*37 + 0x5A) mod 256`.

Master states: M_IDLE (waiting for start), M_ACCESS (request high, window counting), M_DONE (request released, waiting for the slave to go idle). Master transitions: M_IDLE to M_ACCESS on start. M_ACCESS to M_DONE when the window has elapsed and wait is low. M_DONE to M_IDLE when wait is low. Slave states: S_IDLE, S_BUSY (counting latency, wait high if slow), S_VALID (byte on the bus). Slave transitions: S_IDLE to S_BUSY when it sees the request, or straight to S_VALID when `LAT` is 1. S_BUSY to S_VALID when the latency count is reached. S_BUSY or S_VALID back to S_IDLE once the request is low.

Top module: `strobe_rd_top`

## Requirements
- R1: During and right after reset, `bus_req`, `bus_wait`, `bus_data` and `done` are all 0.
- R2: A `start` sampled while the master is idle raises `bus_req` from the very next clock edge.
- R3: With `LAT <= TA` the wait line stays 0 at all times.
- R4: With `LAT > TA` the wait line rises in the cycle after the slave sees the request, and it is low again when the byte is taken.
- R5: The byte returned for address `a` equals `(a*37 + 0x5A) mod 256`, truncated to 8 bits.
- R6: `done` rises exactly `max(TA, LAT) + 1` clock edges after the edge that accepted `start`. The master never captures while wait is high.
- R7: `done` is high for one cycle only, and `bus_req` is already low in that cycle.
- R8: `bus_data` is 0 whenever `bus_req` is low.
- R9: A `start` that arrives while a read is in progress is ignored. No extra `done` follows, and `rd_data` keeps the first read's byte.
- R10: Reads issued back to back, each after the previous `done`, all complete with correct data and timing. This holds because the slave returns to idle once the request drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a read (sampled while idle) |
| addr | input | AW | Address of the byte to read |
| rd_data | output | DW | Last captured byte |
| done | output | 1 | One-cycle pulse when rd_data is new |
| bus_req | output | 1 | Request line, master to slave |
| bus_wait | output | 1 | Wait line, slave to master |
| bus_data | output | DW | Data bus, slave to master |

## Verification
Three latency settings are run against the same master. A slow slave (`LAT` 6, `TA` 3) shows the handshake path and the stretched `done` timing. A slave with `LAT` equal to `TA` shows the boundary where wait must stay low. A slave answering well inside the window (`LAT` 1, `TA` 4) shows that the master still waits out the full window. Each setting is driven with several addresses, including 0 and the highest address, in back-to-back reads. A second start is also issued in the middle of a read. This separates correct data and latency from mistakes in the counting, a wait line that fires early or late, and a master that restarts while busy.

// File: rtl/bus_rd_pkg.sv
`timescale 1ns/1ps
package bus_rd_pkg;
    typedef enum logic [1:0] {M_IDLE, M_ACCESS, M_DONE} mst_state_t;
    typedef enum logic [1:0] {S_IDLE, S_BUSY, S_VALID} slv_state_t;

    localparam int CELL_MULT = 37;
    localparam int CELL_BASE = 90;

    function automatic logic [7:0] cell_value(input int idx);
        return 8'((idx * CELL_MULT + CELL_BASE) % 256);
    endfunction
endpackage

// File: rtl/rd_master.sv
`timescale 1ns/1ps
module rd_master
    import bus_rd_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8,
    parameter int TA = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    input  logic          wait_i,
    input  logic [DW-1:0] data_i,
    output logic          req_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] rd_data_o,
    output logic          done_o
);
    localparam int CW = $clog2(TA + 1) + 1;

    mst_state_t    state, state_nx;
    logic [CW-1:0] win_cnt;
    logic          capture;

    assign capture = (state == M_ACCESS) && (win_cnt >= CW'(TA)) && !wait_i;

    always_comb begin
        state_nx = state;
        unique case (state)
            M_IDLE:   if (start_i) state_nx = M_ACCESS;
            M_ACCESS: if (capture) state_nx = M_DONE;
            M_DONE:   if (!wait_i) state_nx = M_IDLE;
            default:  state_nx = M_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= M_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt   <= '0;
            addr_o    <= '0;
            rd_data_o <= '0;
            done_o    <= 1'b0;
        end else begin
            done_o <= capture;
            if (state == M_IDLE && start_i) begin
                win_cnt <= '0;
                addr_o  <= addr_i;
            end else if (state == M_ACCESS && win_cnt < CW'(TA)) begin
                win_cnt <= win_cnt + 1'b1;
            end
            if (capture) rd_data_o <= data_i;
        end
    end

    assign req_o = (state == M_ACCESS);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R7
    req_low_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !req_o);
    // R6
    no_capture_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && wait_i) |=> !done_o);
endmodule

// File: rtl/rd_slave.sv
`timescale 1ns/1ps
module rd_slave
    import bus_rd_pkg::*;
#(
    parameter int AW  = 4,
    parameter int DW  = 8,
    parameter int TA  = 3,
    parameter int LAT = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [AW-1:0] addr_i,
    output logic          wait_o,
    output logic [DW-1:0] data_o
);
    localparam int  DEPTH = 1 << AW;
    localparam int  CW    = $clog2(LAT + 1) + 1;
    localparam bit  SLOW  = (LAT > TA);

    slv_state_t    state, state_nx;
    logic [CW-1:0] lat_cnt;
    logic [DW-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n) cells[g] <= DW'(cell_value(g));
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:
                if (req_i) state_nx = (LAT <= 1) ? S_VALID : S_BUSY;
            S_BUSY:
                if (!req_i)                        state_nx = S_IDLE;
                else if (lat_cnt + 1'b1 >= CW'(LAT)) state_nx = S_VALID;
            S_VALID:
                if (!req_i) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt <= '0;
        end else if (state == S_IDLE) begin
            lat_cnt <= CW'(1);
        end else if (state == S_BUSY) begin
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    always_comb begin
        wait_o = SLOW && (state == S_BUSY);
        data_o = (req_i && state == S_VALID) ? cells[addr_i] : '0;
    end

    if (SLOW) begin : g_slow_chk
        // R4
        wait_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(req_i) |=> wait_o);
    end else begin : g_fast_chk
        // R3
        fast_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wait_o);
    end
endmodule

// File: rtl/strobe_rd_top.sv
`timescale 1ns/1ps
module strobe_rd_top #(
    parameter int AW  = 4,
    parameter int DW  = 8,
    parameter int TA  = 3,
    parameter int LAT = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] rd_data,
    output logic          done,
    output logic          bus_req,
    output logic          bus_wait,
    output logic [DW-1:0] bus_data
);
    logic [AW-1:0] bus_addr;

    rd_master #(.AW(AW), .DW(DW), .TA(TA)) u_mst (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .addr_i    (addr),
        .wait_i    (bus_wait),
        .data_i    (bus_data),
        .req_o     (bus_req),
        .addr_o    (bus_addr),
        .rd_data_o (rd_data),
        .done_o    (done)
    );

    rd_slave #(.AW(AW), .DW(DW), .TA(TA), .LAT(LAT)) u_slv (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (bus_req),
        .addr_i (bus_addr),
        .wait_o (bus_wait),
        .data_o (bus_data)
    );

    // R8
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> (bus_data == '0));
    // R10
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req)) |-> $stable(bus_addr));
endmodule

// File: tb/sim_strobe_rd_top.sv
`timescale 1ns/1ps
module sim_strobe_rd_top;
    localparam int N = 3;
    localparam int TA_V  [N] = '{3, 3, 4};
    localparam int LAT_V [N] = '{6, 3, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic       start_s [N];
    logic [3:0] addr_s  [N];
    logic [7:0] rdd_s   [N];
    logic       done_s  [N];
    logic       req_s   [N];
    logic       wt_s    [N];
    logic [7:0] bd_s    [N];

    strobe_rd_top #(.TA(3), .LAT(6)) u0 (.clk(clk), .rst_n(rst_n), .start(start_s[0]),
        .addr(addr_s[0]), .rd_data(rdd_s[0]), .done(done_s[0]), .bus_req(req_s[0]),
        .bus_wait(wt_s[0]), .bus_data(bd_s[0]));
    strobe_rd_top #(.TA(3), .LAT(3)) u1 (.clk(clk), .rst_n(rst_n), .start(start_s[1]),
        .addr(addr_s[1]), .rd_data(rdd_s[1]), .done(done_s[1]), .bus_req(req_s[1]),
        .bus_wait(wt_s[1]), .bus_data(bd_s[1]));
    strobe_rd_top #(.TA(4), .LAT(1)) u2 (.clk(clk), .rst_n(rst_n), .start(start_s[2]),
        .addr(addr_s[2]), .rd_data(rdd_s[2]), .done(done_s[2]), .bus_req(req_s[2]),
        .bus_wait(wt_s[2]), .bus_data(bd_s[2]));

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int exp_dat [N][$];
    int exp_cyc [N][$];
    bit fast_wait_seen [N];
    bit bus_leak_seen  [N];
    bit extra_done     [N];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_byte(input int a);
        return (a * 37 + 90) % 256;
    endfunction

    function automatic int max_lat(input int i);
        return (TA_V[i] > LAT_V[i]) ? TA_V[i] : LAT_V[i];
    endfunction

    // monitor: pops the scoreboard as done pulses appear
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < N; i++) begin
                if (LAT_V[i] <= TA_V[i] && wt_s[i]) fast_wait_seen[i] = 1'b1;
                if (!req_s[i] && bd_s[i] != 8'd0) bus_leak_seen[i] = 1'b1;
                if (done_s[i]) begin
                    if (exp_dat[i].size() == 0) begin
                        extra_done[i] = 1'b1;
                    end else begin
                        int ed;
                        int ec;
                        ed = exp_dat[i].pop_front();
                        ec = exp_cyc[i].pop_front();
                        chk(rdd_s[i] == 8'(ed), "R5 data", int'(rdd_s[i]), ed);
                        chk(cyc == ec, "R6 done timing", cyc, ec);
                        chk(!req_s[i], "R7 req low at done", int'(req_s[i]), 0);
                        chk(!wt_s[i], "R4 wait low at capture", int'(wt_s[i]), 0);
                    end
                end
            end
        end
    end

    task automatic do_read(input int i, input int a, input bit twin);
        @(negedge clk);
        start_s[i] = 1'b1;
        addr_s[i]  = 4'(a);
        exp_dat[i].push_back(model_byte(a));
        exp_cyc[i].push_back(cyc + max_lat(i) + 2);
        @(negedge clk);
        start_s[i] = 1'b0;
        chk(req_s[i], "R2 req after start", int'(req_s[i]), 1);
        @(negedge clk);
        if (LAT_V[i] > TA_V[i]) chk(wt_s[i], "R4 wait raised", int'(wt_s[i]), 1);
        else                    chk(!wt_s[i], "R3 no wait", int'(wt_s[i]), 0);
        if (twin) begin
            start_s[i] = 1'b1;
            addr_s[i]  = 4'((a + 5) % 16);
            @(negedge clk);
            start_s[i] = 1'b0;
        end
        wait (exp_dat[i].size() == 0);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            start_s[i] = 1'b0;
            addr_s[i]  = '0;
        end
        repeat (3) @(negedge clk);
        for (int i = 0; i < N; i++) begin
            chk(!req_s[i] && !wt_s[i] && !done_s[i] && bd_s[i] == 0, "R1 reset state",
                int'(req_s[i]) + int'(wt_s[i]) + int'(done_s[i]) + int'(bd_s[i]), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < N; i++)
            chk(!req_s[i] && !done_s[i], "R1 after reset",
                int'(req_s[i]) + int'(done_s[i]), 0);

        // R10 back-to-back reads over several addresses per setting
        for (int i = 0; i < N; i++) begin
            do_read(i, 0, 1'b0);
            do_read(i, 15, 1'b0);
            do_read(i, 7, 1'b0);
            do_read(i, 10, 1'b0);
        end
        // R9 start during an active read is ignored
        for (int i = 0; i < N; i++) begin
            do_read(i, 3, 1'b1);
            repeat (12) @(negedge clk);
            chk(!extra_done[i], "R9 no extra done", int'(extra_done[i]), 0);
            chk(rdd_s[i] == 8'(model_byte(3)), "R9 data kept", int'(rdd_s[i]), model_byte(3));
        end
        for (int i = 0; i < N; i++) begin
            chk(!fast_wait_seen[i], "R3 wait never seen", int'(fast_wait_seen[i]), 0);
            chk(!bus_leak_seen[i], "R8 idle bus zero", int'(bus_leak_seen[i]), 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule